// File: doc/BRIEF.md
# Isolated Digital I/O Port Peripheral

A byte-wide peripheral on a simple synchronous port bus. It drives sixteen output lines, samples sixteen input lines and raises one interrupt line. The bus side decodes a window of eight byte offsets. Two offsets accept writes that load the low and high bytes of the output lines. Two other offsets return the synchronised low and high bytes of the inputs when read.

Every input passes through a two-stage synchroniser. A change in any bit of the synchronised inputs counts as an event, whether the bit rises or falls. While the interrupt is enabled, an event latches a single shared pending flag, and that flag drives the interrupt output.

No data bits control the interrupt. Each control action is a side effect of an access:

- Reading the control offset turns the interrupt on.
- Writing the control offset turns it off.
- Writing the low input offset clears the pending flag.

Read data is registered. It appears on the clock edge that samples the read strobe and returns to zero afterwards.

Top module: `iso_dio_port`

## Requirements
- R1: A write to offset 0 loads `dout[7:0]` from `wr_data`, and a write to offset 4 loads `dout[15:8]`. The other byte keeps its value. The new value is visible after the clock edge that samples the write strobe.
- R2: After reset, `dout` is 16'hFFFF, `irq` is 0, the interrupt is disabled and `rd_data` is 8'h00.
- R3: A read of offset 1 returns `din[7:0]` and a read of offset 5 returns `din[15:8]`. In both cases the value is the one seen through the two-stage synchroniser, and it is presented on `rd_data` after the edge that samples `rd_en`. `rd_data` is 8'h00 in any cycle without a read.
- R4: Reads of offsets 0, 2, 3, 4, 6 and 7 return 8'h00. Reads of offsets 0, 3, 4, 6 and 7 have no side effect. Writes to offsets 1, 2, 3, 5, 6 and 7 leave `dout` unchanged.
- R5: A read of offset 2 enables the interrupt.
- R6: While the interrupt is enabled, any rising or falling change of any input bit sets the pending flag. `irq` goes high after the third clock edge following the pin change.
- R7: The pending flag, and so `irq`, stays set until a write to offset 1 clears it. The written data is ignored, and `irq` is low after the edge that samples that write.
- R8: If a clear write and a new input event occur in the same cycle, the pending flag stays set.
- R9: A write to offset 2 disables the interrupt and clears the pending flag, so `irq` is low after that edge. Input changes while disabled set nothing, and a later enable starts with `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| din | input | 16 | Asynchronous input lines |
| dout | output | 16 | Output drive lines |
| irq | output | 1 | Combined interrupt request |

## Verification
Two of this block's functions can fall in the same cycle: a clear write to offset 1 and a freshly detected input event. The bench first leaves the pending flag set. It then toggles an input pin and times the clear strobe so that the clear is sampled on the edge where the new event is seen, which is the third edge after the pin change. It judges the result by requiring `irq` to still be high afterwards, and then confirms that a lone clear does drop it.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;

    localparam int LANE_W      = 8;
    localparam int LANES       = 2;
    localparam int PINS        = LANE_W * LANES;
    localparam int ADDR_W      = 3;
    localparam int SYNC_STAGES = 2;
    localparam int LANE_STRIDE = 4;
    localparam logic [PINS-1:0] OUT_RST_VAL = '1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_OUT_LO  = 3'd0,
        OFS_IN_LO   = 3'd1,
        OFS_IRQ_CTL = 3'd2,
        OFS_OUT_HI  = 3'd4,
        OFS_IN_HI   = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANE_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [LANES-1:0] out_wr;
        logic [LANES-1:0] in_rd;
        logic             irq_en;
        logic             irq_dis;
        logic             irq_clr;
    } access_t;

    function automatic logic [ADDR_W-1:0] out_ofs(input int lane);
        return ADDR_W'(lane * LANE_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] in_ofs(input int lane);
        return ADDR_W'(lane * LANE_STRIDE + 1);
    endfunction

    function automatic access_t decode_access(input bus_req_t r);
        access_t a;
        a = '0;
        for (int i = 0; i < LANES; i++) begin
            a.out_wr[i] = r.wr && (r.addr == out_ofs(i));
            a.in_rd[i]  = r.rd && (r.addr == in_ofs(i));
        end
        a.irq_en  = r.rd && (r.addr == OFS_IRQ_CTL);
        a.irq_dis = r.wr && (r.addr == OFS_IRQ_CTL);
        a.irq_clr = r.wr && (r.addr == in_ofs(0));
        return a;
    endfunction

endpackage

// File: rtl/dio_sync_edge.sv
module dio_sync_edge #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sync_o,
    output logic         change_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= pins_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign sync_o   = stage_q[STAGES-1];
    assign change_o = |(stage_q[STAGES-1] ^ prev_q);

endmodule

// File: rtl/dio_out_regs.sv
module dio_out_regs
    import iso_dio_pkg::*;
#(
    parameter int            NLANES = LANES,
    parameter int            LW     = LANE_W,
    parameter logic [NLANES*LW-1:0] RST_VAL = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NLANES-1:0]    lane_wr_i,
    input  logic [LW-1:0]        wdata_i,
    output logic [NLANES*LW-1:0] dout_o
);
    genvar i;
    generate
        for (i = 0; i < NLANES; i++) begin : g_lane
            logic [LW-1:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst)               lane_q <= RST_VAL[i*LW +: LW];
                else if (lane_wr_i[i]) lane_q <= wdata_i;
            end
            assign dout_o[i*LW +: LW] = lane_q;

            // R1
            lane_load_chk: assert property (@(posedge clk) disable iff (rst)
                lane_wr_i[i] |=> (dout_o[i*LW +: LW] == $past(wdata_i)));
            // R4
            lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !lane_wr_i[i] |=> $stable(dout_o[i*LW +: LW]));
        end
    endgenerate

endmodule

// File: rtl/dio_irq_ctrl.sv
module dio_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_req_i,
    input  logic dis_req_i,
    input  logic clr_req_i,
    input  logic change_i,
    output logic irq_o
);
    logic en_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (dis_req_i) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (en_req_i) en_q <= 1'b1;
            if (en_q && change_i) pend_q <= 1'b1;
            else if (clr_req_i)   pend_q <= 1'b0;
        end
    end

    assign irq_o = pend_q & en_q;

    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        dis_req_i |=> !irq_o);
    // R9
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !pend_q) |=> !pend_q);
    // R6
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && change_i && !dis_req_i) |=> irq_o);
    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req_i && !change_i && !dis_req_i) |=> !pend_q);
    // R8
    clear_loses_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req_i && change_i && en_q && !dis_req_i) |=> pend_q);

endmodule

// File: rtl/iso_dio_port.sv
module iso_dio_port
    import iso_dio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        irq
);
    bus_req_t        req;
    access_t         acc;
    logic [PINS-1:0] pins_sync;
    logic            pin_change;
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] rd_next;

    assign req = '{rd: rd_en, wr: wr_en, addr: addr, wdata: wr_data};
    assign acc = decode_access(req);

    dio_sync_edge #(.W(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pins_i   (din),
        .sync_o   (pins_sync),
        .change_o (pin_change)
    );

    dio_out_regs #(.NLANES(LANES), .LW(LANE_W), .RST_VAL(OUT_RST_VAL)) outs_i (
        .clk       (clk),
        .rst       (rst),
        .lane_wr_i (acc.out_wr),
        .wdata_i   (req.wdata),
        .dout_o    (dout)
    );

    dio_irq_ctrl irqc_i (
        .clk       (clk),
        .rst       (rst),
        .en_req_i  (acc.irq_en),
        .dis_req_i (acc.irq_dis),
        .clr_req_i (acc.irq_clr),
        .change_i  (pin_change),
        .irq_o     (irq)
    );

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < LANES; i++) begin
            if (acc.in_rd[i]) rd_next = pins_sync[i*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_next;
    end

    assign rd_data = rd_q;

    // R4
    blank_read_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.in_rd == '0) |=> (rd_data == '0));
    // R3
    lane_read_chk: assert property (@(posedge clk) disable iff (rst)
        acc.in_rd[0] |=> (rd_data == $past(pins_sync[LANE_W-1:0])));

endmodule

// File: tb/iso_dio_port_tb.sv
module iso_dio_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    iso_dio_port dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .din(din), .dout(dout), .irq(irq)
    );

    typedef struct packed {
        logic        rd;
        logic [2:0]  a;
        logic [7:0]  d;
        logic [15:0] pins;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 8'hA5, 16'h0000, 16'hFFA5},
        '{1'b0, 3'd4, 8'h3C, 16'h0000, 16'h3CA5},
        '{1'b0, 3'd1, 8'hFF, 16'h0000, 16'h3CA5},
        '{1'b0, 3'd3, 8'hFF, 16'h0000, 16'h3CA5},
        '{1'b0, 3'd5, 8'h00, 16'h0000, 16'h3CA5},
        '{1'b0, 3'd7, 8'h00, 16'h0000, 16'h3CA5},
        '{1'b1, 3'd1, 8'h00, 16'h12F0, 16'h00F0},
        '{1'b1, 3'd5, 8'h00, 16'h12F0, 16'h0012},
        '{1'b1, 3'd5, 8'h00, 16'h8001, 16'h0080},
        '{1'b1, 3'd1, 8'h00, 16'h8001, 16'h0001},
        '{1'b1, 3'd0, 8'h00, 16'h8001, 16'h0000},
        '{1'b1, 3'd3, 8'h00, 16'h8001, 16'h0000},
        '{1'b1, 3'd4, 8'h00, 16'h8001, 16'h0000},
        '{1'b1, 3'd6, 8'h00, 16'h8001, 16'h0000},
        '{1'b1, 3'd7, 8'h00, 16'h8001, 16'h0000},
        '{1'b0, 3'd0, 8'h00, 16'h8001, 16'h3C00},
        '{1'b0, 3'd4, 8'hFF, 16'h8001, 16'hFF00}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle_pins(input logic [15:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic string vec_tag(input vec_t v);
        if (v.rd) return (v.a == 3'd1 || v.a == 3'd5) ? "R3" : "R4";
        return (v.a == 3'd0 || v.a == 3'd4) ? "R1" : "R4";
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check(dout == 16'hFFFF, "R2", dout, 16'hFFFF);
        check(irq == 1'b0, "R2", {15'd0, irq}, 16'd0);
        check(rd_data == 8'h00, "R2", {8'd0, rd_data}, 16'd0);

        // Table walk: R1 output lanes, R3 input reads, R4 blank reads/writes
        for (int i = 0; i < NV; i++) begin
            settle_pins(VEC[i].pins);
            if (VEC[i].rd) begin
                bus_read(VEC[i].a, rv);
                check(rv == VEC[i].exp[7:0], vec_tag(VEC[i]), {8'd0, rv}, VEC[i].exp);
            end else begin
                bus_write(VEC[i].a, VEC[i].d);
                check(dout == VEC[i].exp, vec_tag(VEC[i]), dout, VEC[i].exp);
            end
        end
        @(negedge clk);
        // R3 rd_data idle after read
        check(rd_data == 8'h00, "R3", {8'd0, rd_data}, 16'd0);

        // R4 blank reads did not enable; R9 changes while disabled ignored
        settle_pins(16'h0001);
        check(irq == 1'b0, "R4", {15'd0, irq}, 16'd0);

        // R5 enable by read of offset 2, which returns zero
        bus_read(3'd2, rv);
        check(rv == 8'h00, "R4", {8'd0, rv}, 16'd0);
        check(irq == 1'b0, "R5", {15'd0, irq}, 16'd0);

        // R6 rising edge on bit 9, exact latency
        @(negedge clk);
        din = 16'h0201;
        repeat (2) @(negedge clk);
        check(irq == 1'b0, "R6", {15'd0, irq}, 16'd0);
        @(negedge clk);
        check(irq == 1'b1, "R6", {15'd0, irq}, 16'd1);

        // R7 holds without clear
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R7", {15'd0, irq}, 16'd1);
        bus_write(3'd1, 8'h5A);
        check(irq == 1'b0, "R7", {15'd0, irq}, 16'd0);

        // R6 falling edge on bit 0
        settle_pins(16'h0200);
        check(irq == 1'b1, "R6", {15'd0, irq}, 16'd1);

        // R8 clear sampled on the same edge as a new event
        @(negedge clk);
        din = 16'h0000;
        repeat (2) @(negedge clk);
        addr = 3'd1; wr_data = 8'hFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(irq == 1'b1, "R8", {15'd0, irq}, 16'd1);
        bus_write(3'd1, 8'h00);
        check(irq == 1'b0, "R7", {15'd0, irq}, 16'd0);

        // R9 disable while pending
        settle_pins(16'h8000);
        check(irq == 1'b1, "R6", {15'd0, irq}, 16'd1);
        bus_write(3'd2, 8'hFF);
        check(irq == 1'b0, "R9", {15'd0, irq}, 16'd0);
        settle_pins(16'h0000);
        check(irq == 1'b0, "R9", {15'd0, irq}, 16'd0);
        bus_read(3'd2, rv);
        repeat (2) @(negedge clk);
        check(irq == 1'b0, "R9", {15'd0, irq}, 16'd0);
        settle_pins(16'h0010);
        check(irq == 1'b1, "R5", {15'd0, irq}, 16'd1);
        check(dout == 16'hFF00, "R1", dout, 16'hFF00);

        finished = 1'b1;
        summary();
    end

endmodule